// File: doc/BRIEF.md
# Condition-Code ALU Flag Unit

This block is the integer arithmetic and flag stage of a small processor core. Each accepted operation works on 8-, 16- or 32-bit operands and produces a sized result with a write-back strobe. It also updates the N, Z, V and C flags held in an 8-bit condition-code register. Every operation class has its own flag rule. Compare updates flags without writing a result. Increment and decrement keep carry. The address add and subtract operations change no flags. Logical operations and moves clear V and keep C.

Three immediate operations modify the whole condition-code register directly with AND, OR or XOR. A condition selector is evaluated against the current flags at all times and gives the branch-taken bit used by the fetch stage.

Top module: `ccr_alu_unit`

## Requirements
- R1: When `rst_ni` goes low, `res_o`, `wr_en_o` and `ccr_o` clear to zero at once, without waiting for a clock edge.
- R2: Work is captured on a rising clock edge while `valid_i` is high. The op codes are: 0 add, 1 sub, 2 compare, 3 increment, 4 decrement, 5 and, 6 or, 7 xor, 8 move, 9 address add, 10 address subtract, 11 flag-and, 12 flag-or, 13 flag-xor. Op codes 14 and 15 do nothing. `wr_en_o` is a one-cycle pulse after a writing op. While `valid_i` is low, or for a do-nothing op, `res_o` and `ccr_o` hold.
- R3: Add gives the sized sum a+b. C is set when the sized sum is unsigned-smaller than either operand. V is set when both operands have the same sign and the sum's sign differs from it. The result is written.
- R4: Sub gives the sized a-b. C is set when a is unsigned-less than b. V is set when the operand signs differ and the result's sign differs from a. The result is written.
- R5: Compare sets the same flags as sub. It does not write: `wr_en_o` stays low and `res_o` holds.
- R6: Increment and decrement give a+1 and a-1 at the selected size and write the result. Increment sets V only when a is the largest positive value of the size. Decrement sets V only when a is the most negative value of the size. C is unchanged.
- R7: And, or and xor give a&b, a|b and a^b. Move gives b. All four write the result, set N and Z from it, clear V and leave C unchanged.
- R8: Address add and subtract give the 32-bit a plus or minus the zero-extended `imm_i`, whatever the size select. The result is written and all of `ccr_o` is unchanged.
- R9: Flag-and, flag-or and flag-xor combine all 8 bits of `ccr_o` with `imm_i` and do not write. Every other op changes only `ccr_o[3:0]`.
- R10: Flag positions are N=bit 3, Z=bit 2, V=bit 1 and C=bit 0. N is the sign bit of the sized result and Z is set when the sized result is zero. Size select 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. Operand bits above the size are ignored, and result bits above it are zero.
- R11: `taken_o` is combinational from `cond_i` and `ccr_o`. The codes are: 0 always, 1 never, 2 C and Z both clear, 3 C or Z set, 4 C clear, 5 C set, 6 Z clear, 7 Z set, 8 V clear, 9 V set, 10 N clear, 11 N set.
- R12: The signed conditions are: 12 when N equals V, 13 when N differs from V, 14 when Z or (N xor V) is 0, and 15 (the complement of 14) when Z or (N xor V) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size select |
| a_i | input | 32 | Destination operand |
| b_i | input | 32 | Source operand |
| imm_i | input | 8 | Immediate for address and flag ops |
| cond_i | input | 4 | Branch condition selector |
| res_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Result write pulse |
| ccr_o | output | 8 | Condition-code register |
| taken_o | output | 1 | Branch condition true |

## Verification
The hardest behaviour to reach is a kept flag meeting a live one. A faulty design could clear C on an increment or a logical op, and that only shows when C was 1 beforehand. The bench therefore forces C with a flag-or before the increment sweep and toggles it with a flag-xor before the decrement sweep. The 8-bit sweeps are near-exhaustive, so every sign and carry boundary is crossed with garbage in the unused upper operand bits. The condition selector is then swept over all 16 flag nibbles loaded through the flag-or op.

// File: rtl/ccalu_pkg.sv
package ccalu_pkg;
  parameter int unsigned DW     = 32;  // must be at least 32
  parameter int unsigned CCR_W  = 8;
  parameter int unsigned OP_W   = 4;
  parameter int unsigned IMM_W  = 8;
  parameter int unsigned COND_W = 4;
  localparam int unsigned N_LANES = 3;
  localparam int unsigned F_N = 3;
  localparam int unsigned F_Z = 2;
  localparam int unsigned F_V = 1;
  localparam int unsigned F_C = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,  OP_SUB   = 4'd1,  OP_CMP   = 4'd2,  OP_INC   = 4'd3,
    OP_DEC   = 4'd4,  OP_AND   = 4'd5,  OP_OR    = 4'd6,  OP_XOR   = 4'd7,
    OP_MOV   = 4'd8,  OP_ADDA  = 4'd9,  OP_SUBA  = 4'd10, OP_FAND  = 4'd11,
    OP_FOR   = 4'd12, OP_FXOR  = 4'd13, OP_NOP0  = 4'd14, OP_NOP1  = 4'd15
  } op_e;

  function automatic logic [DW-1:0] size_mask(logic [1:0] s);
    case (s)
      2'd0:    size_mask = DW'(32'h0000_00ff);
      2'd1:    size_mask = DW'(32'h0000_ffff);
      default: size_mask = '1;
    endcase
  endfunction

  function automatic logic sized_msb(logic [DW-1:0] r, logic [1:0] s);
    case (s)
      2'd0:    sized_msb = r[7];
      2'd1:    sized_msb = r[15];
      default: sized_msb = r[31];
    endcase
  endfunction
endpackage

// File: rtl/ccalu_arith.sv
module ccalu_arith
  import ccalu_pkg::*;
(
  input  op_e             op_i,
  input  logic [1:0]      size_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   res_o,
  output logic            cout_o,
  output logic            ovf_o
);
  logic [DW-1:0] opb;
  logic          cin;

  // sub/cmp as a + ~b + 1; inc as a + 0 + 1; dec as a + all-ones
  always_comb begin
    case (op_i)
      OP_SUB, OP_CMP: begin opb = ~b_i; cin = 1'b1; end
      OP_INC:         begin opb = '0;   cin = 1'b1; end
      OP_DEC:         begin opb = '1;   cin = 1'b0; end
      default:        begin opb = b_i;  cin = 1'b0; end
    endcase
  end

  logic [DW-1:0]      lane_res [N_LANES];
  logic [N_LANES-1:0] lane_c;
  logic [N_LANES-1:0] lane_v;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    localparam int unsigned W = 8 << k;
    logic [W:0] sum;
    assign sum         = {1'b0, a_i[W-1:0]} + {1'b0, opb[W-1:0]} + {{W{1'b0}}, cin};
    assign lane_res[k] = DW'(sum[W-1:0]);
    assign lane_c[k]   = sum[W];
    assign lane_v[k]   = (a_i[W-1] == opb[W-1]) && (sum[W-1] != a_i[W-1]);
  end

  always_comb begin
    case (size_i)
      2'd0:    begin res_o = lane_res[0]; cout_o = lane_c[0]; ovf_o = lane_v[0]; end
      2'd1:    begin res_o = lane_res[1]; cout_o = lane_c[1]; ovf_o = lane_v[1]; end
      default: begin res_o = lane_res[2]; cout_o = lane_c[2]; ovf_o = lane_v[2]; end
    endcase
  end
endmodule

// File: rtl/ccalu_logic.sv
module ccalu_logic
  import ccalu_pkg::*;
(
  input  op_e           op_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] raw;

  always_comb begin
    case (op_i)
      OP_AND:  raw = a_i & b_i;
      OP_OR:   raw = a_i | b_i;
      OP_XOR:  raw = a_i ^ b_i;
      default: raw = b_i;
    endcase
    res_o = raw & size_mask(size_i);
  end
endmodule

// File: rtl/ccalu_cond.sv
module ccalu_cond
  import ccalu_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic [3:0]        nzvc_i,
  output logic              taken_o
);
  logic n, z, v, c, gt;

  always_comb begin
    n  = nzvc_i[F_N];
    z  = nzvc_i[F_Z];
    v  = nzvc_i[F_V];
    c  = nzvc_i[F_C];
    gt = !(z | (n ^ v));
    case (cond_i)
      4'd0:    taken_o = 1'b1;
      4'd1:    taken_o = 1'b0;
      4'd2:    taken_o = !(c | z);
      4'd3:    taken_o = c | z;
      4'd4:    taken_o = !c;
      4'd5:    taken_o = c;
      4'd6:    taken_o = !z;
      4'd7:    taken_o = z;
      4'd8:    taken_o = !v;
      4'd9:    taken_o = v;
      4'd10:   taken_o = !n;
      4'd11:   taken_o = n;
      4'd12:   taken_o = !(n ^ v);
      4'd13:   taken_o = n ^ v;
      4'd14:   taken_o = gt;
      default: taken_o = !gt;
    endcase
  end
endmodule

// File: rtl/ccr_alu_unit.sv
module ccr_alu_unit
  import ccalu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [1:0]        size_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [DW-1:0]     res_o,
  output logic              wr_en_o,
  output logic [CCR_W-1:0]  ccr_o,
  output logic              taken_o
);
  op_e            op;
  logic [DW-1:0]  ar_res, lg_res;
  logic           ar_cout, ar_ovf;
  logic [DW-1:0]  res_q, res_d;
  logic [CCR_W-1:0] ccr_q, ccr_d;
  logic           wr_q, wr_d;
  logic           ar_n, ar_z, lg_n, lg_z, c_q;

  assign op = op_e'(op_i);

  ccalu_arith u_arith (
    .op_i(op), .size_i(size_i), .a_i(a_i), .b_i(b_i),
    .res_o(ar_res), .cout_o(ar_cout), .ovf_o(ar_ovf)
  );

  ccalu_logic u_logic (
    .op_i(op), .size_i(size_i), .a_i(a_i), .b_i(b_i), .res_o(lg_res)
  );

  always_comb begin
    ar_n  = sized_msb(ar_res, size_i);
    ar_z  = (ar_res == '0);
    lg_n  = sized_msb(lg_res, size_i);
    lg_z  = (lg_res == '0);
    c_q   = ccr_q[F_C];
    res_d = res_q;
    ccr_d = ccr_q;
    wr_d  = 1'b0;
    case (op)
      OP_ADD: begin
        res_d = ar_res; wr_d = 1'b1;
        ccr_d[3:0] = {ar_n, ar_z, ar_ovf, ar_cout};
      end
      OP_SUB: begin
        res_d = ar_res; wr_d = 1'b1;
        ccr_d[3:0] = {ar_n, ar_z, ar_ovf, !ar_cout};
      end
      OP_CMP:  ccr_d[3:0] = {ar_n, ar_z, ar_ovf, !ar_cout};
      OP_INC, OP_DEC: begin
        res_d = ar_res; wr_d = 1'b1;
        ccr_d[3:0] = {ar_n, ar_z, ar_ovf, c_q};
      end
      OP_AND, OP_OR, OP_XOR, OP_MOV: begin
        res_d = lg_res; wr_d = 1'b1;
        ccr_d[3:0] = {lg_n, lg_z, 1'b0, c_q};
      end
      OP_ADDA: begin res_d = a_i + DW'(imm_i); wr_d = 1'b1; end
      OP_SUBA: begin res_d = a_i - DW'(imm_i); wr_d = 1'b1; end
      OP_FAND: ccr_d = ccr_q & CCR_W'(imm_i);
      OP_FOR:  ccr_d = ccr_q | CCR_W'(imm_i);
      OP_FXOR: ccr_d = ccr_q ^ CCR_W'(imm_i);
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      ccr_q <= '0;
      wr_q  <= 1'b0;
    end else if (valid_i) begin
      res_q <= res_d;
      ccr_q <= ccr_d;
      wr_q  <= wr_d;
    end else begin
      wr_q  <= 1'b0;
    end
  end

  ccalu_cond u_cond (.cond_i(cond_i), .nzvc_i(ccr_q[3:0]), .taken_o(taken_o));

  assign res_o   = res_q;
  assign ccr_o   = ccr_q;
  assign wr_en_o = wr_q;

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o) && $stable(ccr_o) && !wr_en_o);
  a_r5_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CMP |=> !wr_en_o && $stable(res_o));
  a_r6_keep_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_INC || op_i == OP_DEC) |=> ccr_o[F_C] == $past(ccr_o[F_C]));
  a_r7_logic_clears_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i >= OP_AND && op_i <= OP_MOV |=> !ccr_o[F_V]);
  a_r8_addr_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_ADDA || op_i == OP_SUBA) |=> $stable(ccr_o) && wr_en_o);
  a_r9_upper_ccr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i <= OP_SUBA |=> ccr_o[7:4] == $past(ccr_o[7:4]));
  a_r10_byte_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i == 2'd0 && op_i <= OP_MOV && op_i != OP_CMP |=> res_o[DW-1:8] == '0);
  a_r11_always_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'd0 |-> taken_o) and (cond_i == 4'd1 |-> !taken_o));
endmodule

// File: tb/tb_ccr_alu_unit.sv
`timescale 1ns/1ps
module tb_ccr_alu_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [7:0]  imm_i = '0;
  logic [3:0]  cond_i = '0;
  logic [31:0] res_o;
  logic        wr_en_o;
  logic [7:0]  ccr_o;
  logic        taken_o;

  always #10 clk = ~clk;

  ccr_alu_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
    .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .cond_i(cond_i),
    .res_o(res_o), .wr_en_o(wr_en_o), .ccr_o(ccr_o), .taken_o(taken_o)
  );

  int          n_chk = 0, n_bad = 0;
  logic [31:0] e_res = '0;
  logic        e_wr = 1'b0;
  logic [7:0]  e_ccr = '0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(logic [1:0] s);
    return (s == 2'd0) ? 32'hff : (s == 2'd1) ? 32'hffff : 32'hffff_ffff;
  endfunction

  function automatic logic sgn(logic [31:0] x, logic [1:0] s);
    return (x & ((msk(s) >> 1) + 32'd1)) != 32'd0;
  endfunction

  function automatic string tag(logic [3:0] op);
    case (op)
      4'd0: return "R3";  4'd1: return "R4";  4'd2: return "R5";
      4'd3, 4'd4: return "R6";
      4'd5, 4'd6, 4'd7, 4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      4'd11, 4'd12, 4'd13: return "R9";
      default: return "R2";
    endcase
  endfunction

  // reference model built from the requirement text
  task automatic model(logic [3:0] op, logic [1:0] s, logic [31:0] a, logic [31:0] b, logic [7:0] imm);
    logic [31:0] m, sa, sb, r;
    logic n, z, v, c;
    m = msk(s); sa = a & m; sb = b & m;
    r = 32'd0; v = 1'b0; c = e_ccr[0];
    e_wr = 1'b0;
    case (op)
      4'd0: begin r = (sa + sb) & m; c = (r < sa) || (r < sb);
              v = (sgn(sa, s) == sgn(sb, s)) && (sgn(r, s) != sgn(sa, s)); end
      4'd1, 4'd2: begin r = (sa - sb) & m; c = sa < sb;
              v = (sgn(sa, s) != sgn(sb, s)) && (sgn(r, s) != sgn(sa, s)); end
      4'd3: begin r = (sa + 32'd1) & m; v = (sa == (m >> 1)); end
      4'd4: begin r = (sa - 32'd1) & m; v = (sa == (m >> 1) + 32'd1); end
      4'd5: r = sa & sb;
      4'd6: r = sa | sb;
      4'd7: r = sa ^ sb;
      4'd8: r = sb;
      default: ;
    endcase
    n = sgn(r, s); z = (r == 32'd0);
    case (op)
      4'd0, 4'd1, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8: begin
        e_res = r; e_wr = 1'b1; e_ccr[3:0] = {n, z, v, c};
      end
      4'd2: e_ccr[3:0] = {n, z, v, c};
      4'd9:  begin e_res = a + {24'd0, imm}; e_wr = 1'b1; end
      4'd10: begin e_res = a - {24'd0, imm}; e_wr = 1'b1; end
      4'd11: e_ccr = e_ccr & imm;
      4'd12: e_ccr = e_ccr | imm;
      4'd13: e_ccr = e_ccr ^ imm;
      default: ;
    endcase
  endtask

  task automatic apply(logic [3:0] op, logic [1:0] s, logic [31:0] a, logic [31:0] b, logic [7:0] imm);
    string t;
    model(op, s, a, b, imm);
    t = tag(op);
    @(negedge clk);
    op_i = op; size_i = s; a_i = a; b_i = b; imm_i = imm; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk(t, "res_o", res_o, e_res);
    chk(t, "wr_en_o", {31'd0, wr_en_o}, {31'd0, e_wr});
    chk(t, "ccr_o", {24'd0, ccr_o}, {24'd0, e_ccr});
  endtask

  function automatic logic exp_taken(logic [3:0] c, logic [3:0] f);
    logic n, z, v, cy;
    {n, z, v, cy} = f;
    case (c)
      4'd0: return 1'b1;       4'd1: return 1'b0;
      4'd2: return !cy && !z;  4'd3: return cy || z;
      4'd4: return !cy;        4'd5: return cy;
      4'd6: return !z;         4'd7: return z;
      4'd8: return !v;         4'd9: return v;
      4'd10: return !n;        4'd11: return n;
      4'd12: return n == v;    4'd13: return n != v;
      4'd14: return (z || (n != v)) == 1'b0;
      default: return (z || (n != v)) == 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] corner(int i, logic [1:0] s);
    case (i)
      0: return 32'd0;
      1: return 32'd1;
      2: return msk(s) >> 1;
      3: return (msk(s) >> 1) + 32'd1;
      4: return msk(s);
      5: return 32'h5a5a_a5a5;
      default: return 32'hdead_be7f;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1", "res_o at reset", res_o, 32'd0);
    chk("R1", "wr_en_o at reset", {31'd0, wr_en_o}, 32'd0);
    chk("R1", "ccr_o at reset", {24'd0, ccr_o}, 32'd0);
    rst_ni = 1'b1;

    // R9 preset upper CCR bits that later ops must keep
    apply(4'd12, 2'd0, 32'd0, 32'd0, 8'hA0);

    // R3 R4 R5 near-exhaustive 8-bit, garbage in upper bits (R10)
    for (int op = 0; op < 3; op++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 16; j++)
          apply(4'(op), 2'd0, {24'hc3a51e, 8'(a)}, {24'h3c5ae1, 8'(j * 17)}, 8'd0);

    // R6 increment with C forced to 1, decrement with C toggled to 0
    apply(4'd12, 2'd0, 32'd0, 32'd0, 8'h01);
    for (int a = 0; a < 256; a++) apply(4'd3, 2'd0, {24'hffffff, 8'(a)}, 32'd0, 8'd0);
    apply(4'd13, 2'd0, 32'd0, 32'd0, 8'h01);
    for (int a = 0; a < 256; a++) apply(4'd4, 2'd0, {24'h123456, 8'(a)}, 32'd0, 8'd0);

    // R7 logic and move at 8 bits
    apply(4'd12, 2'd0, 32'd0, 32'd0, 8'h01);
    for (int op = 5; op < 9; op++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 8; j++)
          apply(4'(op), 2'd0, {24'h00ff00, 8'(a)}, {24'h0f0f0f, 8'(j * 37)}, 8'd0);

    // R10 corner operands at wider sizes, including size code 3
    for (int s = 1; s < 4; s++)
      for (int op = 0; op < 9; op++)
        for (int i = 0; i < 7; i++)
          for (int j = 0; j < 7; j++)
            apply(4'(op), 2'(s), corner(i, 2'(s)), corner(j, 2'(s)), 8'd0);

    // pseudo-random operands for all sized ops
    for (int s = 1; s < 4; s++)
      for (int op = 0; op < 9; op++)
        for (int k = 0; k < 300; k++)
          apply(4'(op), 2'(s), $urandom, $urandom, 8'd0);

    // R8 address add/sub including wrap, across all sizes
    apply(4'd9, 2'd0, 32'hffff_ffff, 32'd0, 8'd1);
    apply(4'd10, 2'd1, 32'd0, 32'd0, 8'd1);
    apply(4'd9, 2'd0, 32'h0000_00ff, 32'd0, 8'hff);
    for (int k = 0; k < 400; k++)
      apply(4'(9 + (k % 2)), 2'(k % 4), $urandom, $urandom, 8'($urandom));

    // R9 immediate flag ops
    for (int k = 0; k < 300; k++)
      apply(4'(11 + (k % 3)), 2'(k % 4), $urandom, $urandom, 8'($urandom));

    // R2 do-nothing ops and idle cycles hold state
    apply(4'd14, 2'd2, 32'hffff_ffff, 32'h1, 8'hff);
    apply(4'd15, 2'd0, 32'h0, 32'h0, 8'h00);
    @(negedge clk);
    op_i = 4'd0; a_i = 32'h1234_5678; b_i = 32'h1111_1111; valid_i = 1'b0;
    @(negedge clk);
    chk("R2", "res_o idle", res_o, e_res);
    chk("R2", "wr_en_o idle", {31'd0, wr_en_o}, 32'd0);
    chk("R2", "ccr_o idle", {24'd0, ccr_o}, {24'd0, e_ccr});

    // R11 R12 every condition against every flag nibble
    for (int f = 0; f < 16; f++) begin
      apply(4'd11, 2'd0, 32'd0, 32'd0, 8'h00);
      apply(4'd12, 2'd0, 32'd0, 32'd0, 8'(f) | 8'h50);
      for (int c = 0; c < 16; c++) begin
        cond_i = 4'(c);
        #0.5;
        chk((c >= 12) ? "R12" : "R11", "taken_o", {31'd0, taken_o},
            {31'd0, exp_taken(4'(c), 4'(f))});
      end
    end

    // R1 asynchronous reset mid-cycle
    apply(4'd12, 2'd0, 32'd0, 32'd0, 8'hff);
    apply(4'd8, 2'd2, 32'd0, 32'h8000_0001, 8'd0);
    @(negedge clk);
    #3 rst_ni = 1'b0;
    #1;
    chk("R1", "res_o async clear", res_o, 32'd0);
    chk("R1", "ccr_o async clear", {24'd0, ccr_o}, 32'd0);
    chk("R1", "wr_en_o async clear", {31'd0, wr_en_o}, 32'd0);

    summary();
    $finish;
  end
endmodule